// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter

This block is a three-tap finite impulse response filter. It takes one 8-bit sample per clock and produces y(n) = a·x(n) + b·x(n-1) + c·x(n-2). The coefficients a, b and c are inputs that can change at run time. A two-register delay line holds x(n-1) and x(n-2). Each sample is multiplied by its coefficient, and the three products go through an adder tree. A parameter sets whether samples and coefficients are two's complement or unsigned.

A compile-time parameter picks one of three places for pipeline registers. Each choice sits on a cut that every path crosses in the forward direction:
- **No registers.** The result is combinational. The path is one multiplier plus two adders.
- **Registered products.** The path is two adders, with one cycle of latency.
- **Registered products plus a partial-sum stage.** The path is one adder, with two cycles of latency.

A designer uses this choice to study how critical path trades against latency.

Samples enter and results leave through valid/ready streams. Back-pressure stalls the whole pipeline at once:
- `in_ready` mirrors `out_ready`.
- A sample is taken only in a cycle where `in_valid` and `out_ready` are both high.
- While `out_ready` is low, every register holds.

Top module: `fir3_pipe`

## Requirements
- R1: Each result equals a·x(n) + b·x(n-1) + c·x(n-2), exact and not rounded. x(n-1) and x(n-2) are the two samples accepted before x(n) since reset. The coefficients are those present on the cycle x(n) is accepted. Coefficient inputs map as follows: `coef_cur` to a, `coef_prev1` to b, `coef_prev2` to c.
- R2: Taps not yet filled since reset count as zero. With a=2, b=7, c=11 and samples 3, 5, 1, the first three results are 6, 31 and 70.
- R3: `out_result` is 2·DW+2 bits wide and never overflows.
  - In unsigned mode, all-ones samples and coefficients give 195075.
  - In signed mode, 0x80 everywhere gives +49152, and 0xFF everywhere gives 3.
- R4: With CUT=1 a result leaves 1 advancing cycle after its sample is accepted. With CUT=2 it leaves after 2 advancing cycles. An advancing cycle is one with `out_ready` high. `out_valid` is delayed by the same amount.
- R5: With CUT=0 the result and `out_valid` appear in the same cycle the sample is presented.
- R6: Back-pressure rules:
  - `in_ready` always equals `out_ready`.
  - In the registered modes, while `out_ready` is low, `out_valid` and `out_result` hold.
  - No sample is taken.
- R7: A cycle with `in_valid` low does not shift the delay line. Such a cycle produces no result.
- R8: With SIGNED=1, samples and coefficients are two's complement; with SIGNED=0 they are unsigned. With a=2, b=c=0 and sample 0xFF, the result is -2 (0x3FFFE) signed and 510 unsigned.
- R9: A synchronous reset, active high on `rst`, clears the delay line, every pipeline register and the valid pipeline. After reset `out_valid` is 0 and `out_result` is 0 until a sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present on `in_sample` |
| in_ready | output | 1 | Sample taken this cycle when high with `in_valid` |
| in_sample | input | DW | New sample x(n) |
| coef_cur | input | DW | Coefficient a for x(n) |
| coef_prev1 | input | DW | Coefficient b for x(n-1) |
| coef_prev2 | input | DW | Coefficient c for x(n-2) |
| out_valid | output | 1 | `out_result` holds a filter result |
| out_ready | input | 1 | Downstream accepts the result; also advances the pipeline |
| out_result | output | 2·DW+2 | Filter result y(n) |

## Verification
Each result is due a fixed number of advancing cycles after its sample is accepted: 0 with no cut, 1 with registered products and 2 with the partial-sum stage. Cycles with `out_ready` low do not count. The bench stamps every accepted sample with a running count of advancing cycles. Each transferred result must carry a stamp exactly the mode's latency behind, in addition to the right value. Inputs change on the falling edge and outputs are read 2 ns later, so a combinational result from the no-cut variant is seen in the cycle of its sample. The bench runs four variants side by side on the same stream and compares each against its own expected value and latency.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  typedef enum logic [1:0] {
    CUT_NONE     = 2'd0,
    CUT_PRODUCTS = 2'd1,
    CUT_PARTIAL  = 2'd2
  } fir3_cut_e;

  localparam int FIR3_TAPS = 3;

  function automatic int fir3_sum_width(input int dw);
    return 2 * dw + 2;
  endfunction
endpackage

// File: rtl/fir3_tapline.sv
module fir3_tapline #(
  parameter int DW   = 8,
  parameter int TAPS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift_en,
  input  logic [DW-1:0]             din,
  output logic [TAPS-1:0][DW-1:0]   taps
);
  assign taps[0] = din;

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (shift_en) q <= taps[i-1];
    end
    assign taps[i] = q;
  end
endmodule

// File: rtl/fir3_mults.sv
module fir3_mults #(
  parameter int DW     = 8,
  parameter int TAPS   = 3,
  parameter int PW     = 2 * DW + 2,
  parameter bit SIGNED = 1'b1
) (
  input  logic [TAPS-1:0][DW-1:0] taps,
  input  logic [TAPS-1:0][DW-1:0] coefs,
  output logic [TAPS-1:0][PW-1:0] prods
);
  for (genvar i = 0; i < TAPS; i++) begin : g_mul
    logic signed [DW:0]   x_ext;
    logic signed [DW:0]   c_ext;
    logic signed [PW-1:0] p;
    if (SIGNED) begin : g_s
      assign x_ext = {taps[i][DW-1], taps[i]};
      assign c_ext = {coefs[i][DW-1], coefs[i]};
    end else begin : g_u
      assign x_ext = {1'b0, taps[i]};
      assign c_ext = {1'b0, coefs[i]};
    end
    assign p        = PW'(x_ext) * PW'(c_ext);
    assign prods[i] = p;
  end
endmodule

// File: rtl/fir3_sum.sv
module fir3_sum
  import fir3_pkg::*;
#(
  parameter int        PW  = 18,
  parameter fir3_cut_e CUT = CUT_PARTIAL
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         adv,
  input  logic                         vin,
  input  logic [FIR3_TAPS-1:0][PW-1:0] prods,
  output logic [PW-1:0]                res,
  output logic                         vout
);
  if (CUT == CUT_NONE) begin : g_comb
    logic unused_seq;
    assign unused_seq = ^{clk, rst, adv};
    assign res  = prods[0] + prods[1] + prods[2];
    assign vout = vin;
  end else if (CUT == CUT_PRODUCTS) begin : g_prod
    logic [FIR3_TAPS-1:0][PW-1:0] p_q;
    logic                         v_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q <= '0;
        v_q <= 1'b0;
      end else if (adv) begin
        p_q <= prods;
        v_q <= vin;
      end
    end
    assign res  = p_q[0] + p_q[1] + p_q[2];
    assign vout = v_q;
  end else begin : g_part
    logic [FIR3_TAPS-1:0][PW-1:0] p_q;
    logic                         v1_q;
    logic [PW-1:0]                s01_q;
    logic [PW-1:0]                s2_q;
    logic                         v2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_q   <= '0;
        v1_q  <= 1'b0;
        s01_q <= '0;
        s2_q  <= '0;
        v2_q  <= 1'b0;
      end else if (adv) begin
        p_q   <= prods;
        v1_q  <= vin;
        s01_q <= p_q[0] + p_q[1];
        s2_q  <= p_q[2];
        v2_q  <= v1_q;
      end
    end
    assign res  = s01_q + s2_q;
    assign vout = v2_q;
  end
endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe
  import fir3_pkg::*;
#(
  parameter int        DW     = 8,
  parameter fir3_cut_e CUT    = CUT_PARTIAL,
  parameter bit        SIGNED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_sample,
  input  logic [DW-1:0]     coef_cur,
  input  logic [DW-1:0]     coef_prev1,
  input  logic [DW-1:0]     coef_prev2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*DW+1:0]   out_result
);
  localparam int SW = fir3_sum_width(DW);

  logic                          take;
  logic [FIR3_TAPS-1:0][DW-1:0]  taps;
  logic [FIR3_TAPS-1:0][DW-1:0]  coefs;
  logic [FIR3_TAPS-1:0][SW-1:0]  prods;

  assign in_ready = out_ready;
  assign take     = in_valid & out_ready;
  assign coefs    = {coef_prev2, coef_prev1, coef_cur};

  fir3_tapline #(.DW(DW), .TAPS(FIR3_TAPS)) u_tapline (
    .clk      (clk),
    .rst      (rst),
    .shift_en (take),
    .din      (in_sample),
    .taps     (taps)
  );

  fir3_mults #(.DW(DW), .TAPS(FIR3_TAPS), .PW(SW), .SIGNED(SIGNED)) u_mults (
    .taps  (taps),
    .coefs (coefs),
    .prods (prods)
  );

  fir3_sum #(.PW(SW), .CUT(CUT)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .adv   (out_ready),
    .vin   (in_valid),
    .prods (prods),
    .res   (out_result),
    .vout  (out_valid)
  );
endmodule

// File: rtl/fir3_pipe_chk.sv
module fir3_pipe_chk
  import fir3_pkg::*;
#(
  parameter int        DW     = 8,
  parameter fir3_cut_e CUT    = CUT_PARTIAL,
  parameter bit        SIGNED = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2*DW+1:0] out_result
);
  localparam int UMAX = 3 * ((2 ** DW) - 1) * ((2 ** DW) - 1);
  localparam int SMAX = 3 * (2 ** (DW - 1)) * (2 ** (DW - 1));
  localparam int SMIN = -3 * (2 ** (DW - 1)) * ((2 ** (DW - 1)) - 1);

  // Shadow of the valid flag, advanced only on advancing cycles
  logic [1:0] vshadow;
  always_ff @(posedge clk) begin
    if (rst)            vshadow <= 2'b00;
    else if (out_ready) vshadow <= {vshadow[0], in_valid};
  end

  assert_ready_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    in_ready == out_ready);

  if (CUT != CUT_NONE) begin : g_reg
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
    assert_clear_R9: assert property (@(posedge clk)
      rst |=> !out_valid);
  end

  if (CUT == CUT_PRODUCTS) begin : g_l1
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid == vshadow[0]);
  end else if (CUT == CUT_PARTIAL) begin : g_l2
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid == vshadow[1]);
  end else begin : g_l0
    assert_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);
  end

  if (SIGNED) begin : g_rs
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'($signed(out_result)) <= SMAX &&
                     int'($signed(out_result)) >= SMIN));
  end else begin : g_ru
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_result) <= UMAX));
  end
endmodule

bind fir3_pipe fir3_pipe_chk #(.DW(DW), .CUT(CUT), .SIGNED(SIGNED)) u_fir3_pipe_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/fir3_pipe_bench.sv
module fir3_pipe_bench;
  import fir3_pkg::*;

  localparam int N = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic [7:0] ca = '0, cb = '0, cc = '0;
  logic       out_ready = 1'b1;

  logic [17:0] res   [4];
  logic        vld   [4];
  logic        rdy_o [4];

  int dmode [4] = '{0, 1, 2, 1};
  bit dsig  [4] = '{1'b1, 1'b1, 1'b1, 1'b0};

  always #4 clk = ~clk;

  fir3_pipe #(.DW(8), .CUT(CUT_NONE), .SIGNED(1'b1)) u_fir3_pipe_m0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_o[0]), .in_sample(in_sample),
    .coef_cur(ca), .coef_prev1(cb), .coef_prev2(cc),
    .out_valid(vld[0]), .out_ready(out_ready), .out_result(res[0]));
  fir3_pipe #(.DW(8), .CUT(CUT_PRODUCTS), .SIGNED(1'b1)) u_fir3_pipe_m1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_o[1]), .in_sample(in_sample),
    .coef_cur(ca), .coef_prev1(cb), .coef_prev2(cc),
    .out_valid(vld[1]), .out_ready(out_ready), .out_result(res[1]));
  fir3_pipe u_fir3_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_o[2]), .in_sample(in_sample),
    .coef_cur(ca), .coef_prev1(cb), .coef_prev2(cc),
    .out_valid(vld[2]), .out_ready(out_ready), .out_result(res[2]));
  fir3_pipe #(.DW(8), .CUT(CUT_PRODUCTS), .SIGNED(1'b0)) u_fir3_pipe_u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_o[3]), .in_sample(in_sample),
    .coef_cur(ca), .coef_prev1(cb), .coef_prev2(cc),
    .out_valid(vld[3]), .out_ready(out_ready), .out_result(res[3]));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int    hs   [N];
  int    hu   [N];
  int    hadv [N];
  string htag [N];
  int    wr = 0;
  int    ptr [4];
  int    adv = 0;
  int    since_rst = 0;
  string cur_tag = "R1";
  logic [7:0] h1 = '0, h2 = '0;

  logic [17:0] prev_res [4];
  logic        prev_vld [4];
  logic        prev_ready = 1'b1;

  function automatic int ival(bit sgn, logic [7:0] v);
    return sgn ? int'($signed(v)) : int'(v);
  endfunction

  function automatic int model(bit sgn, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                               logic [7:0] x0, logic [7:0] x1, logic [7:0] x2);
    return ival(sgn, a) * ival(sgn, x0) + ival(sgn, b) * ival(sgn, x1) + ival(sgn, c) * ival(sgn, x2);
  endfunction

  function automatic int dutval(bit sgn, logic [17:0] r);
    return sgn ? int'($signed(r)) : int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic observe();
    for (int k = 0; k < 4; k++)
      check(rdy_o[k] == out_ready, "R6", "in_ready mirrors out_ready", int'(rdy_o[k]), int'(out_ready));
    if (in_valid && out_ready) begin
      hs[wr]   = model(1'b1, ca, cb, cc, in_sample, h1, h2);
      hu[wr]   = model(1'b0, ca, cb, cc, in_sample, h1, h2);
      hadv[wr] = adv;
      htag[wr] = (since_rst < 2) ? "R2" : cur_tag;
      wr++;
      since_rst++;
      h2 = h1;
      h1 = in_sample;
    end
    for (int k = 0; k < 4; k++) begin
      if (dmode[k] > 0 && !prev_ready) begin
        check(vld[k] == prev_vld[k], "R6", "valid held under stall", int'(vld[k]), int'(prev_vld[k]));
        if (prev_vld[k])
          check(res[k] == prev_res[k], "R6", "result held under stall", int'(res[k]), int'(prev_res[k]));
      end
      if (vld[k] && out_ready) begin
        if (ptr[k] >= wr) begin
          check(1'b0, "R7", "result with no pending sample", 1, 0);
        end else begin
          int e;
          e = dsig[k] ? hs[ptr[k]] : hu[ptr[k]];
          check(dutval(dsig[k], res[k]) == e, htag[ptr[k]], $sformatf("value dut%0d", k),
                dutval(dsig[k], res[k]), e);
          check(adv == hadv[ptr[k]] + dmode[k], (dmode[k] == 0) ? "R5" : "R4",
                $sformatf("latency dut%0d", k), adv - hadv[ptr[k]], dmode[k]);
          ptr[k]++;
        end
      end
      prev_res[k] = res[k];
      prev_vld[k] = vld[k];
    end
    prev_ready = out_ready;
    if (out_ready) adv++;
  endtask

  task automatic step(input bit v, input logic [7:0] x, input bit rdy);
    @(negedge clk);
    in_valid  = v;
    in_sample = x;
    out_ready = rdy;
    #2;
    observe();
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sample = '0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #2;
    for (int k = 0; k < 4; k++) begin
      ptr[k] = wr;
      prev_vld[k] = 1'b0;
      check(vld[k] == 1'b0, "R9", $sformatf("valid after reset dut%0d", k), int'(vld[k]), 0);
      check(res[k] == '0, "R9", $sformatf("result after reset dut%0d", k), int'(res[k]), 0);
    end
    prev_ready = 1'b1;
    h1 = '0; h2 = '0;
    since_rst = 0;
  endtask

  task automatic finish_run();
    for (int k = 0; k < 4; k++)
      check(ptr[k] == wr, "R1", $sformatf("all results delivered dut%0d", k), ptr[k], wr);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) ptr[k] = 0;
    do_reset();

    // R2: unfilled taps contribute zero
    ca = 8'd2; cb = 8'd7; cc = 8'd11;
    step(1'b1, 8'd3, 1'b1);
    step(1'b1, 8'd5, 1'b1);
    cur_tag = "R1";
    step(1'b1, 8'd1, 1'b1);
    flush();

    // R7: bubbles between samples do not shift the delay line
    do_reset();
    cur_tag = "R7";
    step(1'b1, 8'd9, 1'b1);
    step(1'b0, 8'd77, 1'b1);
    step(1'b0, 8'd55, 1'b1);
    step(1'b1, 8'd4, 1'b1);
    step(1'b0, 8'd33, 1'b1);
    step(1'b1, 8'd6, 1'b1);
    flush();

    // R6: stalls with data in flight
    cur_tag = "R6";
    step(1'b1, 8'd20, 1'b1);
    step(1'b1, 8'd21, 1'b0);
    step(1'b1, 8'd22, 1'b0);
    step(1'b1, 8'd23, 1'b1);
    step(1'b1, 8'd24, 1'b0);
    step(1'b0, 8'd0, 1'b1);
    flush();

    // R8: signedness interpretation
    do_reset();
    cur_tag = "R8";
    ca = 8'd2; cb = 8'd0; cc = 8'd0;
    step(1'b1, 8'hFF, 1'b1);
    step(1'b1, 8'h80, 1'b1);
    step(1'b1, 8'h7F, 1'b1);
    flush();

    // R3: extreme operands
    do_reset();
    cur_tag = "R3";
    ca = 8'h80; cb = 8'h80; cc = 8'h80;
    for (int i = 0; i < 4; i++) step(1'b1, 8'h80, 1'b1);
    flush();
    ca = 8'hFF; cb = 8'hFF; cc = 8'hFF;
    for (int i = 0; i < 4; i++) step(1'b1, 8'hFF, 1'b1);
    flush();

    // R1: random stream with random back-pressure
    cur_tag = "R1";
    for (int blk = 0; blk < 6; blk++) begin
      ca = 8'($urandom); cb = 8'($urandom); cc = 8'($urandom);
      for (int i = 0; i < 500; i++)
        step(($urandom % 4) != 0, 8'($urandom), ($urandom % 10) < 7);
      flush();
    end

    // R9: reset with a full pipeline, then R2 again
    for (int i = 0; i < 3; i++) step(1'b1, 8'($urandom), 1'b1);
    do_reset();
    ca = 8'd2; cb = 8'd7; cc = 8'd11;
    step(1'b1, 8'd3, 1'b1);
    step(1'b1, 8'd5, 1'b1);
    cur_tag = "R1";
    step(1'b1, 8'd1, 1'b1);
    flush();

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule